// File: doc/BRIEF.md
# Shared-Bus Flash and PSRAM Access Controller

This block sits on the host side of a memory package in which a flash die and a pseudo-SRAM die share one address bus and one 16-bit data bus. A host hands it one request at a time through a valid/ready port. Each request names a target: the flash array, the PSRAM array, or one of the two PSRAM configuration registers. The block then runs one asynchronous bus access and drives the chip enables, output and write strobes, byte lane enables, configuration-register select and data-bus drive enable for it.

Every access passes through four phases. Each phase lasts a whole number of clock cycles, and each length is a parameter: address setup, strobe, hold, and a turnaround gap with both dies deselected. The block returns a one-cycle completion pulse, together with the read data, in the cycle after the strobe ends. The clock that runs to the memories is held low throughout, because only asynchronous accesses are issued. The address-latch strobe stays low for as long as either die is selected. Between accesses both chip enables are high. This is also the state the PSRAM needs to stay in deep power-down after a refresh-register write that clears its bit 4.

Top module: `membus_ctrl`

## Requirements
- R1: During reset and whenever no access is in progress, the outputs are as follows. `req_ready` is high. All chip enables, output enables, write enables and byte enables are high. `ps_cre`, `mem_dq_oe`, `mem_clk` and `rsp_done` are low. `rsp_rdata` is zero after reset. An asynchronous reset during an access returns the outputs to this state at once.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low is not taken. After acceptance, `req_ready` is low and comes back high exactly SETUP_CYC+STROBE_CYC+HOLD_CYC+TURN_CYC cycles after the accepting edge.
- R3: The `req_target` codes are 0 = flash, 1 = PSRAM array, 2 = PSRAM configuration register, and 3 = PSRAM array. The chip enable of the selected die is low for SETUP_CYC+STROBE_CYC+HOLD_CYC cycles, starting in the cycle after acceptance. The chip enable of the other die stays high.
- R4: `fl_ce_n` and `ps_ce_n` are never low together. When a die is released, both enables then stay high for at least TURN_CYC+1 cycles before the other die is selected. The gap is exactly TURN_CYC+1 when the next request is already waiting.
- R5: After SETUP_CYC cycles, the selected die's output enable (on a read) or write enable (on a write) is low for exactly STROBE_CYC cycles. The other strobes stay high. A flash write enable therefore rises HOLD_CYC cycles before the flash chip enable.
- R6: In the request mask, bit 1 enables the upper byte (data 15..8) and bit 0 enables the lower byte (data 7..0). On a PSRAM array access, `ps_ub_n` and `ps_lb_n` are the active-low copies of these bits for the whole time the chip enable is low. On a flash access both stay high.
- R7: A PSRAM array access with mask 00 still holds `ps_ce_n` low for the full access, with both byte enables high. If it is a read, it returns zero.
- R8: On a configuration-register access, `ps_cre` is high while `ps_ce_n` is low, and both byte enables are low. Address bits 19..18 are driven as 10 when `req_cfg_sel` is 1 (bus configuration register) and as 00 when it is 0 (refresh configuration register). All other address bits pass through unchanged.
- R9: `mem_dq_oe` is high only while a die is selected for a write, and during that time `mem_dq_o` carries the write data. The data bus is released at all other times.
- R10: Read data is taken from `mem_dq_i` in the last strobe cycle. `rsp_done` pulses for one cycle in the cycle after the last strobe cycle, on reads and on writes alike. On a PSRAM array read, disabled byte lanes return zero. A write leaves `rsp_rdata` unchanged.
- R11: `mem_clk` is always low. `mem_adv_n` is low exactly while one of the chip enables is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 2 | Target code (see R3) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lane enables, active high (bit 1 upper) |
| req_cfg_sel | input | 1 | Configuration register select (1 = bus, 0 = refresh) |
| rsp_done | output | 1 | Access completion pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | ADDR_W | Shared address bus |
| mem_dq_o | output | 16 | Data bus, outbound value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus, inbound value |
| mem_clk | output | 1 | Burst clock, held low |
| mem_adv_n | output | 1 | Address latch strobe, active low |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| ps_ce_n | output | 1 | PSRAM chip enable, active low |
| ps_oe_n | output | 1 | PSRAM output enable, active low |
| ps_we_n | output | 1 | PSRAM write enable, active low |
| ps_ub_n | output | 1 | PSRAM upper byte enable, active low |
| ps_lb_n | output | 1 | PSRAM lower byte enable, active low |
| ps_cre | output | 1 | PSRAM configuration register enable |

## Verification
The bench builds the block with SETUP_CYC=2, STROBE_CYC=3, HOLD_CYC=1 and TURN_CYC=2. Because every phase has a different length from its neighbours, an off-by-one in any phase counter moves a visible edge. With a strobe longer than one cycle, the bench can also tell sampling read data early apart from sampling it in the last strobe cycle. A turnaround of two cycles makes the gap of TURN_CYC+1 between dies distinguishable both from a single idle cycle and from the phase-length sum. Each pin is compared cycle by cycle against a schedule computed from these four values.

// File: rtl/membus_pkg.sv
package membus_pkg;

    localparam int DQ_W = 16;

    localparam logic [1:0] TGT_FLASH = 2'd0;
    localparam logic [1:0] TGT_PSRAM = 2'd1;
    localparam logic [1:0] TGT_PCFG  = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/membus_seq.sv
module membus_seq
    import membus_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4,
    parameter int HOLD_CYC   = 2,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_target,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [1:0]        req_bmask,
    input  logic              req_cfg_sel,
    input  logic [DQ_W-1:0]   mem_dq_i,
    output phase_e            phase,
    output logic              cur_write,
    output logic [1:0]        cur_target,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DQ_W-1:0]   cur_wdata,
    output logic [1:0]        cur_bmask,
    output logic              cur_cfg_sel,
    output logic              rsp_done,
    output logic [DQ_W-1:0]   rsp_rdata
);

    localparam int MAX_LEN = max4(SETUP_CYC, STROBE_CYC, HOLD_CYC, TURN_CYC);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int HALF_W  = DQ_W / 2;

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic                wr;
        logic [1:0]          tgt;
        logic [ADDR_W-1:0]   addr;
        logic [DQ_W-1:0]     wdata;
        logic [1:0]          bm;
        logic                csel;
        logic                done;
        logic [DQ_W-1:0]     rdata;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [CNT_W-1:0] len_m1;
    logic             ph_end;
    logic [DQ_W-1:0]  lane_mask;

    always_comb begin
        case (st_q.ph)
            PH_SETUP:  len_m1 = CNT_W'(SETUP_CYC - 1);
            PH_STROBE: len_m1 = CNT_W'(STROBE_CYC - 1);
            PH_HOLD:   len_m1 = CNT_W'(HOLD_CYC - 1);
            default:   len_m1 = CNT_W'(TURN_CYC - 1);
        endcase
        ph_end = (st_q.cnt == len_m1);
        if (st_q.tgt == TGT_FLASH || st_q.tgt == TGT_PCFG)
            lane_mask = '1;
        else
            lane_mask = {{HALF_W{st_q.bm[1]}}, {HALF_W{st_q.bm[0]}}};

        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph    = PH_SETUP;
                    st_d.cnt   = '0;
                    st_d.wr    = req_write;
                    st_d.tgt   = req_target;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.bm    = req_bmask;
                    st_d.csel  = req_cfg_sel;
                end
            end
            PH_SETUP: begin
                st_d.cnt = ph_end ? '0 : st_q.cnt + 1'b1;
                if (ph_end) st_d.ph = PH_STROBE;
            end
            PH_STROBE: begin
                st_d.cnt = ph_end ? '0 : st_q.cnt + 1'b1;
                if (ph_end) begin
                    st_d.ph   = PH_HOLD;
                    st_d.done = 1'b1;
                    if (!st_q.wr) st_d.rdata = mem_dq_i & lane_mask;
                end
            end
            PH_HOLD: begin
                st_d.cnt = ph_end ? '0 : st_q.cnt + 1'b1;
                if (ph_end) st_d.ph = PH_TURN;
            end
            default: begin
                st_d.cnt = ph_end ? '0 : st_q.cnt + 1'b1;
                if (ph_end) st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready   = (st_q.ph == PH_IDLE);
    assign phase       = st_q.ph;
    assign cur_write   = st_q.wr;
    assign cur_target  = st_q.tgt;
    assign cur_addr    = st_q.addr;
    assign cur_wdata   = st_q.wdata;
    assign cur_bmask   = st_q.bm;
    assign cur_cfg_sel = st_q.csel;
    assign rsp_done    = st_q.done;
    assign rsp_rdata   = st_q.rdata;

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

endmodule

// File: rtl/membus_pins.sv
module membus_pins
    import membus_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int CFG_LSB = 18
) (
    input  phase_e            phase,
    input  logic              cur_write,
    input  logic [1:0]        cur_target,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DQ_W-1:0]   cur_wdata,
    input  logic [1:0]        cur_bmask,
    input  logic              cur_cfg_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DQ_W-1:0]   mem_dq_o,
    output logic              mem_dq_oe,
    output logic              mem_clk,
    output logic              mem_adv_n,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              ps_ce_n,
    output logic              ps_oe_n,
    output logic              ps_we_n,
    output logic              ps_ub_n,
    output logic              ps_lb_n,
    output logic              ps_cre
);

    logic active, strobe, is_fl, is_cfg, is_ps;
    logic [ADDR_W-1:0] addr_v;

    always_comb begin
        active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobe = (phase == PH_STROBE);
        is_fl  = (cur_target == TGT_FLASH);
        is_cfg = (cur_target == TGT_PCFG);
        is_ps  = !is_fl;

        addr_v = cur_addr;
        if (is_cfg) addr_v[CFG_LSB+1:CFG_LSB] = {cur_cfg_sel, 1'b0};

        fl_ce_n   = !(active && is_fl);
        ps_ce_n   = !(active && is_ps);
        fl_oe_n   = !(strobe && is_fl && !cur_write);
        fl_we_n   = !(strobe && is_fl && cur_write);
        ps_oe_n   = !(strobe && is_ps && !cur_write);
        ps_we_n   = !(strobe && is_ps && cur_write);
        ps_ub_n   = !(active && is_ps && (is_cfg || cur_bmask[1]));
        ps_lb_n   = !(active && is_ps && (is_cfg || cur_bmask[0]));
        ps_cre    = active && is_cfg;
        mem_addr  = active ? addr_v : '0;
        mem_dq_o  = cur_wdata;
        mem_dq_oe = active && cur_write;
        mem_adv_n = !active;
        mem_clk   = 1'b0;
    end

endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
    import membus_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int CFG_LSB    = 18,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4,
    parameter int HOLD_CYC   = 2,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_target,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [1:0]        req_bmask,
    input  logic              req_cfg_sel,
    output logic              rsp_done,
    output logic [DQ_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DQ_W-1:0]   mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DQ_W-1:0]   mem_dq_i,
    output logic              mem_clk,
    output logic              mem_adv_n,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              ps_ce_n,
    output logic              ps_oe_n,
    output logic              ps_we_n,
    output logic              ps_ub_n,
    output logic              ps_lb_n,
    output logic              ps_cre
);

    phase_e            phase;
    logic              cur_write, cur_cfg_sel;
    logic [1:0]        cur_target, cur_bmask;
    logic [ADDR_W-1:0] cur_addr;
    logic [DQ_W-1:0]   cur_wdata;

    membus_seq #(
        .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .req_cfg_sel(req_cfg_sel), .mem_dq_i(mem_dq_i),
        .phase(phase), .cur_write(cur_write), .cur_target(cur_target),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_bmask(cur_bmask),
        .cur_cfg_sel(cur_cfg_sel), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    membus_pins #(.ADDR_W(ADDR_W), .CFG_LSB(CFG_LSB)) u_pins (
        .phase(phase), .cur_write(cur_write), .cur_target(cur_target),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_bmask(cur_bmask),
        .cur_cfg_sel(cur_cfg_sel), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_clk(mem_clk), .mem_adv_n(mem_adv_n),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .ps_ce_n(ps_ce_n), .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n),
        .ps_ub_n(ps_ub_n), .ps_lb_n(ps_lb_n), .ps_cre(ps_cre)
    );

    // R4
    ps_sel_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps_ce_n) |-> (fl_ce_n && $past(fl_ce_n)));

    // R4
    fl_sel_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_ce_n) |-> (ps_ce_n && $past(ps_ce_n)));

    // R5
    fl_we_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_ce_n) |-> $past(fl_we_n));

    // R1
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && ps_ce_n && !mem_dq_oe));

    // R9
    drive_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!fl_ce_n || !ps_ce_n));

    // R8
    cre_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_cre |-> !ps_ce_n);

endmodule

// File: tb/membus_ctrl_bench.sv
module membus_ctrl_bench;

    localparam int S  = 2;
    localparam int T  = 3;
    localparam int H  = 1;
    localparam int TN = 2;
    localparam int N  = S + T + H + TN;
    localparam int NV = 11;

    typedef struct packed {
        logic        wr;
        logic [1:0]  tgt;
        logic [22:0] addr;
        logic [15:0] wdata;
        logic [1:0]  bm;
        logic        csel;
        logic [15:0] pat;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 23'h6A1234, 16'h0000, 2'b00, 1'b0, 16'hC3A5},
        '{1'b1, 2'd0, 23'h000F0F, 16'h1357, 2'b00, 1'b0, 16'h0000},
        '{1'b0, 2'd1, 23'h123456, 16'h0000, 2'b11, 1'b0, 16'hBEEF},
        '{1'b0, 2'd1, 23'h0000AA, 16'h0000, 2'b10, 1'b0, 16'hA55A},
        '{1'b0, 2'd3, 23'h0000BB, 16'h0000, 2'b01, 1'b0, 16'h5AA5},
        '{1'b1, 2'd1, 23'h0ABCDE, 16'h2468, 2'b10, 1'b0, 16'h0000},
        '{1'b1, 2'd2, 23'h0C0010, 16'h0070, 2'b00, 1'b1, 16'h0000},
        '{1'b1, 2'd2, 23'h0400EF, 16'h0007, 2'b11, 1'b0, 16'h0000},
        '{1'b0, 2'd2, 23'h000001, 16'h0000, 2'b01, 1'b1, 16'h9D1F},
        '{1'b0, 2'd1, 23'h000042, 16'h0000, 2'b00, 1'b0, 16'hFFFF},
        '{1'b0, 2'd0, 23'h7FFFFF, 16'h0000, 2'b11, 1'b0, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cfg_sel = 1'b0;
    logic [1:0]  req_target = '0, req_bmask = '0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, mem_dq_oe, mem_clk, mem_adv_n;
    logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [22:0] mem_addr;
    logic        fl_ce_n, fl_oe_n, fl_we_n, ps_ce_n, ps_oe_n, ps_we_n;
    logic        ps_ub_n, ps_lb_n, ps_cre;
    logic [15:0] fl_pat = 16'h0, ps_pat = 16'h0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [15:0] exp_rdata = 16'h0;

    always #2.5 clk = ~clk;

    assign mem_dq_i = !fl_oe_n ? fl_pat : (!ps_oe_n ? ps_pat : 16'hDEAD);

    membus_ctrl #(
        .ADDR_W(23), .CFG_LSB(18), .SETUP_CYC(S), .STROBE_CYC(T),
        .HOLD_CYC(H), .TURN_CYC(TN)
    ) u_membus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_target(req_target), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_bmask(req_bmask), .req_cfg_sel(req_cfg_sel),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
        .mem_clk(mem_clk), .mem_adv_n(mem_adv_n), .fl_ce_n(fl_ce_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .ps_ce_n(ps_ce_n),
        .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n), .ps_ub_n(ps_ub_n),
        .ps_lb_n(ps_lb_n), .ps_cre(ps_cre)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tagof(input int k, input bit nomask);
        case (k)
            0: return "R3";
            1: return "R5";
            2: return nomask ? "R7" : "R6";
            3: return "R8";
            4: return "R9";
            5: return nomask ? "R7" : "R10";
            6: return "R2";
            7: return "R11";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [12:0] idle_pins();
        return {req_ready, fl_ce_n, ps_ce_n, fl_oe_n, fl_we_n, ps_oe_n, ps_we_n,
                ps_ub_n, ps_lb_n, ps_cre, mem_dq_oe, mem_clk, rsp_done};
    endfunction

    task automatic present(input vec_t v);
        req_write = v.wr; req_target = v.tgt; req_addr = v.addr;
        req_wdata = v.wdata; req_bmask = v.bm; req_cfg_sel = v.csel;
        req_valid = 1'b1;
    endtask

    task automatic run(input vec_t v);
        bit is_fl, is_cfg, is_ps, nomask, act, stb, ed;
        logic [22:0] eaddr;
        logic [15:0] erd;
        logic [31:0] a [9];
        logic [31:0] e [9];
        bit bad [9];
        logic [31:0] fa [9];
        logic [31:0] fe [9];
        is_fl  = (v.tgt == 2'd0);
        is_cfg = (v.tgt == 2'd2);
        is_ps  = !is_fl;
        nomask = is_ps && !is_cfg && (v.bm == 2'b00);
        eaddr  = v.addr;
        if (is_cfg) eaddr[19:18] = v.csel ? 2'b10 : 2'b00;
        if (v.wr) erd = exp_rdata;
        else if (is_fl || is_cfg) erd = v.pat;
        else erd = v.pat & {{8{v.bm[1]}}, {8{v.bm[0]}}};
        for (int k = 0; k < 9; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
        @(negedge clk);
        fl_pat = v.pat; ps_pat = v.pat;
        present(v);
        @(posedge clk);
        for (int i = 0; i <= N; i++) begin
            @(negedge clk);
            if (i == 0) req_valid = 1'b0;
            act = (i < S + T + H);
            stb = (i >= S) && (i < S + T);
            ed  = (i == S + T);
            a[0] = {30'd0, fl_ce_n, ps_ce_n};
            e[0] = {30'd0, !(act && is_fl), !(act && is_ps)};
            a[1] = {28'd0, fl_oe_n, fl_we_n, ps_oe_n, ps_we_n};
            e[1] = {28'd0, !(stb && is_fl && !v.wr), !(stb && is_fl && v.wr),
                    !(stb && is_ps && !v.wr), !(stb && is_ps && v.wr)};
            a[2] = {30'd0, ps_ub_n, ps_lb_n};
            e[2] = {30'd0, !(act && is_ps && (is_cfg || v.bm[1])),
                    !(act && is_ps && (is_cfg || v.bm[0]))};
            a[3] = {8'd0, ps_cre, act ? mem_addr : 23'd0};
            e[3] = {8'd0, act && is_cfg, act ? eaddr : 23'd0};
            a[4] = {15'd0, mem_dq_oe, (act && v.wr) ? mem_dq_o : 16'd0};
            e[4] = {15'd0, act && v.wr, (act && v.wr) ? v.wdata : 16'd0};
            a[5] = {15'd0, rsp_done, ed ? rsp_rdata : 16'd0};
            e[5] = {15'd0, ed, ed ? erd : 16'd0};
            a[6] = {31'd0, req_ready};
            e[6] = {31'd0, i == N};
            a[7] = {30'd0, mem_clk, mem_adv_n};
            e[7] = {30'd0, 1'b0, !act};
            a[8] = {31'd0, fl_ce_n | ps_ce_n};
            e[8] = 32'd1;
            for (int k = 0; k < 9; k++) begin
                if (a[k] !== e[k] && !bad[k]) begin
                    bad[k] = 1; fa[k] = a[k]; fe[k] = e[k];
                end
            end
        end
        for (int k = 0; k < 9; k++) chk(!bad[k], tagof(k, nomask), fa[k], fe[k]);
        exp_rdata = erd;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int gap;
        bit seen_fl, fl_rel, ps_sel, both_low;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(idle_pins() === 13'b1111111110000 && rsp_rdata === 16'h0, "R1",
            {19'd0, idle_pins()}, {19'd0, 13'b1111111110000});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(idle_pins() === 13'b1111111110000, "R1", {19'd0, idle_pins()}, {19'd0, 13'b1111111110000});

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int n = 0; n < NV; n++) run(VECS[n]);

        // R4: back-to-back flash then PSRAM, second request waiting while busy (R2)
        gap = 0; seen_fl = 0; fl_rel = 0; ps_sel = 0; both_low = 0;
        @(negedge clk);
        fl_pat = 16'h1111; ps_pat = 16'h2222;
        present(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        present(VECS[2]);
        for (int c = 0; c < 40 && !ps_sel; c++) begin
            if (!fl_ce_n && !ps_ce_n) both_low = 1;
            if (!fl_ce_n) seen_fl = 1;
            else if (seen_fl && ps_ce_n) begin fl_rel = 1; gap++; end
            if (!ps_ce_n && fl_rel) begin ps_sel = 1; req_valid = 1'b0; end
            if (!ps_sel) @(negedge clk);
        end
        chk(ps_sel && gap == TN + 1, "R4", gap, TN + 1);
        chk(!both_low, "R4", {31'd0, both_low}, 32'd0);
        while (!req_ready) @(negedge clk);
        chk(rsp_rdata === 16'h2222, "R10", {16'd0, rsp_rdata}, 32'h2222);
        exp_rdata = 16'h2222;

        // R1: asynchronous reset in the middle of a flash write strobe
        @(negedge clk);
        present(VECS[1]);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (S) @(negedge clk);
        chk(fl_we_n === 1'b0, "R5", {31'd0, fl_we_n}, 32'd0);
        rst_n = 1'b0;
        #1;
        chk(idle_pins() === 13'b1111111110000 && rsp_rdata === 16'h0, "R1",
            {19'd0, idle_pins()}, {19'd0, 13'b1111111110000});
        @(negedge clk);
        rst_n = 1'b1;
        exp_rdata = 16'h0;
        run(VECS[1]);
        chk(rsp_rdata === 16'h0, "R10", {16'd0, rsp_rdata}, 32'd0);
        run(VECS[10]);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule